// File: doc/BRIEF.md
# Multi-mode 16-bit timer counter

This block is a 16-bit counter that advances on ticks taken from one of four selectable sources and thinned out by a power-of-two prescaler. All sources are single-cycle enables or a slow level inside one system clock domain. A two-bit mode field makes the counter hold, run from zero up to a programmable period, run freely through the whole 16-bit range, or run up to the period and back down to zero.

The counter reports its value, its present direction, a one-cycle wrap pulse and a one-cycle pulse when an upward step lands on the period value. Both pulses appear in the same cycle as the count value produced by that step. A clear strobe and a direct write port let the surrounding logic restart or preset the count at any time. A preset never raises a pulse.

Top module: `mm_timer16`

## Requirements
- R1: After reset the count is 0, the direction output is 0 (upward) and both pulse outputs are 0.
- R2: With mode_sel = 00 the count and direction hold and no pulse is raised, whatever the tick sources do.
- R3: With mode_sel = 01 and a nonzero period P, the count runs 0,1,..,P,0 so that one cycle lasts P+1 ticks. eq0_pulse is raised on the step that reaches P. wrap_pulse is raised on the step from P to 0.
- R4: In mode 01, a tick that finds the count above P sets the count to 0 without a wrap pulse.
- R5: With mode_sel = 10 the count steps by one and rolls from 0xFFFF to 0 with a wrap pulse. eq0_pulse is raised whenever the new count equals the period.
- R6: With mode_sel = 11 and P nonzero, the count rises to P and then falls to 0, so one cycle lasts 2P ticks. eq0_pulse is raised on the step from P-1 to P. wrap_pulse is raised on the step from 1 to 0. dir_down is 1 while the count is falling.
- R7: The direction is kept while the mode is 00, so mode 11 resumes in the direction it had before the hold.
- R8: clr sets the count to 0, the direction upward and the prescaler to its start, and overrides a write and a tick in the same cycle.
- R9: div_sel selects one counter step per 1 (00), 2 (01), 4 (10) or 8 (11) source ticks.
- R10: src_sel picks the tick: 00 = each rising edge of ext_lvl, 01 = aux_tick, 10 = sub_tick, 11 = each falling edge of ext_lvl. The sources that are not selected have no effect.
- R11: In modes 01 and 11, a period of 0 holds the count at 0 with the direction upward and raises no pulse. A later nonzero period starts counting upward from 0.
- R12: cnt_wr loads cnt_wdata into the count on the next clock edge with no pulse and no extra step, even when a tick arrives in the same cycle.
- R13: In mode 11, if the period is lowered below the count while rising, the next tick turns the count downward. While falling, the count descends to 0 whatever the period is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Tick source select |
| ext_lvl | input | 1 | External clock level, edge-detected |
| aux_tick | input | 1 | Auxiliary clock enable |
| sub_tick | input | 1 | Sub-main clock enable |
| div_sel | input | 2 | Prescaler ratio select |
| mode_sel | input | 2 | Count mode |
| period | input | 16 | Period value |
| clr | input | 1 | Clear strobe |
| cnt_wr | input | 1 | Direct count write enable |
| cnt_wdata | input | 16 | Direct count write value |
| count | output | 16 | Current count |
| dir_down | output | 1 | 1 while counting downward |
| wrap_pulse | output | 1 | One-cycle wrap event |
| eq0_pulse | output | 1 | One-cycle event on an upward step onto the period |

## Verification
On every cycle, the assertions check that a hold keeps the count and direction still and silent. They also check that clear and write land on the next edge with no pulse, that every wrap pulse comes with a zero count, and that every period pulse comes with an upward count equal to the period. Tick counting through the prescaler and the source edge detectors, the exact cycle lengths in each mode, direction retention across a hold, and the turn-around when the period is lowered can only be shown by the bench scenarios. In those scenarios a behavioural model is compared with the outputs on every clock.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

    typedef enum logic [1:0] {
        MODE_HALT = 2'b00,
        MODE_UP   = 2'b01,
        MODE_FREE = 2'b10,
        MODE_UPDN = 2'b11
    } mmt_mode_e;

    typedef enum logic [1:0] {
        SRC_EXT_RISE = 2'b00,
        SRC_AUX      = 2'b01,
        SRC_SUB      = 2'b10,
        SRC_EXT_FALL = 2'b11
    } mmt_src_e;

endpackage

// File: rtl/mmt_tick_select.sv
module mmt_tick_select
    import mmt_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel_i,
    input  logic       ext_lvl_i,
    input  logic       aux_tick_i,
    input  logic       sub_tick_i,
    output logic       tick_o
);

    typedef struct packed {
        logic ext_prev;
    } sel_state_t;

    sel_state_t st_d, st_q;
    logic [N_SRC-1:0] cand;
    logic rise, fall;

    always_comb begin
        st_d          = st_q;
        st_d.ext_prev = ext_lvl_i;
        rise          = ext_lvl_i & ~st_q.ext_prev;
        fall          = ~ext_lvl_i & st_q.ext_prev;
        cand                      = '0;
        cand[int'(SRC_EXT_RISE)]  = rise;
        cand[int'(SRC_AUX)]       = aux_tick_i;
        cand[int'(SRC_SUB)]       = sub_tick_i;
        cand[int'(SRC_EXT_FALL)]  = fall;
        tick_o                    = cand[src_sel_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mmt_prescale.sv
module mmt_prescale #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel_i,
    input  logic             clr_i,
    input  logic             src_tick_i,
    output logic             tick_o
);

    localparam int PRE_W = (2 ** DIV_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] acc;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_W-1:0] limit;
    logic at_limit;

    always_comb begin
        limit    = ~({PRE_W{1'b1}} << div_sel_i);
        at_limit = (st_q.acc == limit);
        st_d     = st_q;
        tick_o   = 1'b0;
        if (clr_i) begin
            st_d.acc = '0;
        end else if (src_tick_i) begin
            if (at_limit) begin
                st_d.acc = '0;
                tick_o   = 1'b1;
            end else begin
                st_d.acc = st_q.acc + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mmt_core.sv
module mmt_core
    import mmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             clr_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             down_o,
    output logic             wrap_o,
    output logic             eq_o
);

    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP_VAL = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic             wrap;
        logic             eq;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [CNT_W-1:0] inc_v, dec_v;
    mmt_mode_e mode_e;

    always_comb begin
        mode_e    = mmt_mode_e'(mode_i);
        inc_v     = st_q.cnt + ONE;
        dec_v     = st_q.cnt - ONE;
        st_d      = st_q;
        st_d.wrap = 1'b0;
        st_d.eq   = 1'b0;
        if (clr_i) begin
            st_d.cnt  = '0;
            st_d.down = 1'b0;
        end else if (wr_i) begin
            st_d.cnt = wdata_i;
        end else if (tick_i) begin
            unique case (mode_e)
                MODE_HALT: begin
                    st_d.cnt = st_q.cnt;
                end
                MODE_UP: begin
                    st_d.down = 1'b0;
                    if (period_i == '0) begin
                        st_d.cnt = '0;
                    end else if (st_q.cnt == period_i) begin
                        st_d.cnt  = '0;
                        st_d.wrap = 1'b1;
                    end else if (st_q.cnt > period_i) begin
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = inc_v;
                        st_d.eq  = (inc_v == period_i);
                    end
                end
                MODE_FREE: begin
                    st_d.down = 1'b0;
                    st_d.cnt  = inc_v;
                    st_d.wrap = (st_q.cnt == TOP_VAL);
                    st_d.eq   = (inc_v == period_i);
                end
                MODE_UPDN: begin
                    if (period_i == '0) begin
                        st_d.cnt  = '0;
                        st_d.down = 1'b0;
                    end else if (!st_q.down && (st_q.cnt < period_i)) begin
                        st_d.cnt = inc_v;
                        st_d.eq  = (inc_v == period_i);
                    end else if (st_q.cnt == '0) begin
                        st_d.cnt  = ONE;
                        st_d.down = 1'b0;
                        st_d.eq   = (period_i == ONE);
                    end else begin
                        st_d.cnt  = dec_v;
                        st_d.down = 1'b1;
                        if (dec_v == '0) begin
                            st_d.wrap = 1'b1;
                            st_d.down = 1'b0;
                        end
                    end
                end
                default: begin
                    st_d.cnt = st_q.cnt;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign down_o = st_q.down;
    assign wrap_o = st_q.wrap;
    assign eq_o   = st_q.eq;

endmodule

// File: rtl/mm_timer16.sv
module mm_timer16
    import mmt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src_sel,
    input  logic             ext_lvl,
    input  logic             aux_tick,
    input  logic             sub_tick,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [1:0]       mode_sel,
    input  logic [CNT_W-1:0] period,
    input  logic             clr,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             wrap_pulse,
    output logic             eq0_pulse
);

    logic src_tick;
    logic cnt_tick;

    mmt_tick_select u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sel_i  (src_sel),
        .ext_lvl_i  (ext_lvl),
        .aux_tick_i (aux_tick),
        .sub_tick_i (sub_tick),
        .tick_o     (src_tick)
    );

    mmt_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_sel_i  (div_sel),
        .clr_i      (clr),
        .src_tick_i (src_tick),
        .tick_o     (cnt_tick)
    );

    mmt_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode_sel),
        .period_i (period),
        .clr_i    (clr),
        .wr_i     (cnt_wr),
        .wdata_i  (cnt_wdata),
        .tick_i   (cnt_tick),
        .cnt_o    (count),
        .down_o   (dir_down),
        .wrap_o   (wrap_pulse),
        .eq_o     (eq0_pulse)
    );

endmodule

// File: rtl/mmt_checker.sv
module mmt_checker
    import mmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic [CNT_W-1:0] period,
    input logic             clr,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic [CNT_W-1:0] count,
    input logic             dir_down,
    input logic             wrap_pulse,
    input logic             eq0_pulse
);

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MODE_HALT && !clr && !cnt_wr) |=>
            ($stable(count) && $stable(dir_down) && !wrap_pulse && !eq0_pulse));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !dir_down && !wrap_pulse && !eq0_pulse));

    // R12
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !clr) |=> (count == $past(cnt_wdata) && !wrap_pulse && !eq0_pulse));

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> (count == '0 && !dir_down));

    // R6
    eq_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eq0_pulse |-> (count == $past(period) && !dir_down));

endmodule

bind mm_timer16 mmt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .period     (period),
    .clr        (clr),
    .cnt_wr     (cnt_wr),
    .cnt_wdata  (cnt_wdata),
    .count      (count),
    .dir_down   (dir_down),
    .wrap_pulse (wrap_pulse),
    .eq0_pulse  (eq0_pulse)
);

// File: tb/mm_timer16_bench.sv
module mm_timer16_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = 2'd0;
    logic        ext_lvl = 1'b0;
    logic        aux_tick = 1'b0;
    logic        sub_tick = 1'b0;
    logic [1:0]  div_sel = 2'd0;
    logic [1:0]  mode_sel = 2'd0;
    logic [15:0] period = 16'd0;
    logic        clr = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_wdata = 16'd0;
    logic [15:0] count;
    logic        dir_down;
    logic        wrap_pulse;
    logic        eq0_pulse;

    int    n_chk = 0;
    int    n_fail = 0;
    int    n_wrap = 0;
    int    n_eq = 0;
    string cur_req = "R1";

    int m_cnt = 0, m_pre = 0;
    bit m_dir = 0, m_ext = 0, m_wrap = 0, m_eq = 0;
    bit st, ct;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mm_timer16 u_mm_timer16 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ext_lvl(ext_lvl),
        .aux_tick(aux_tick), .sub_tick(sub_tick), .div_sel(div_sel),
        .mode_sel(mode_sel), .period(period), .clr(clr), .cnt_wr(cnt_wr),
        .cnt_wdata(cnt_wdata), .count(count), .dir_down(dir_down),
        .wrap_pulse(wrap_pulse), .eq0_pulse(eq0_pulse)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: one step per clock edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_dir = 0; m_pre = 0; m_ext = 0; m_wrap = 0; m_eq = 0;
        end else begin
            case (src_sel)
                2'd0: st = ext_lvl && !m_ext;
                2'd1: st = aux_tick;
                2'd2: st = sub_tick;
                default: st = !ext_lvl && m_ext;
            endcase
            m_ext = ext_lvl;
            m_wrap = 0; m_eq = 0; ct = 0;
            if (clr) m_pre = 0;
            else if (st) begin
                m_pre++;
                if (m_pre >= (1 << div_sel)) begin m_pre = 0; ct = 1; end
            end
            if (clr) begin m_cnt = 0; m_dir = 0; end
            else if (cnt_wr) m_cnt = int'(cnt_wdata);
            else if (ct) begin
                case (mode_sel)
                    2'd1: begin
                        m_dir = 0;
                        if (period == 0) m_cnt = 0;
                        else if (m_cnt == int'(period)) begin m_cnt = 0; m_wrap = 1; end
                        else if (m_cnt > int'(period)) m_cnt = 0;
                        else begin m_cnt++; m_eq = (m_cnt == int'(period)); end
                    end
                    2'd2: begin
                        m_dir = 0;
                        if (m_cnt == 65535) begin m_cnt = 0; m_wrap = 1; end
                        else m_cnt++;
                        m_eq = (m_cnt == int'(period));
                    end
                    2'd3: begin
                        if (period == 0) begin m_cnt = 0; m_dir = 0; end
                        else if (!m_dir && m_cnt < int'(period)) begin
                            m_cnt++; m_eq = (m_cnt == int'(period));
                        end else if (m_cnt == 0) begin
                            m_cnt = 1; m_dir = 0; m_eq = (period == 1);
                        end else begin
                            m_cnt--; m_dir = 1;
                            if (m_cnt == 0) begin m_wrap = 1; m_dir = 0; end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, "count", int'(count), m_cnt);
            check(cur_req, "dir_down", int'(dir_down), int'(m_dir));
            check(cur_req, "wrap_pulse", int'(wrap_pulse), int'(m_wrap));
            check(cur_req, "eq0_pulse", int'(eq0_pulse), int'(m_eq));
            if (wrap_pulse) n_wrap++;
            if (eq0_pulse) n_eq++;
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_clear();
        clr = 1; run(1); clr = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        run(3);
        rst_n = 1;
        run(1);
        cur_req = "R1";
        check("R1", "reset count", int'(count), 0);
        check("R1", "reset dir", int'(dir_down), 0);

        // R3 up mode, P=4, tick every cycle
        cur_req = "R3";
        src_sel = 2'd1; aux_tick = 1; mode_sel = 2'd1; period = 16'd4;
        n_wrap = 0; n_eq = 0;
        run(15);
        check("R3", "wraps in 15 ticks", n_wrap, 3);
        check("R3", "eq0 in 15 ticks", n_eq, 3);
        check("R3", "count after 15 ticks", int'(count), 0);
        run(2);

        // R2 hold
        cur_req = "R2";
        mode_sel = 2'd0; n_wrap = 0;
        run(5);
        check("R2", "held count", int'(count), 2);
        check("R2", "no wraps in hold", n_wrap, 0);

        // R12 write, R5 continuous wrap
        cur_req = "R12";
        cnt_wr = 1; cnt_wdata = 16'hFFFD; run(1); cnt_wr = 0;
        check("R12", "written count", int'(count), 32'hFFFD);
        cur_req = "R5";
        mode_sel = 2'd2; period = 16'd0; n_wrap = 0; n_eq = 0;
        run(4);
        check("R5", "count after rollover", int'(count), 1);
        check("R5", "wraps", n_wrap, 1);
        check("R5", "eq0 at period 0", n_eq, 1);

        // R4 up mode entered above period
        cur_req = "R4";
        mode_sel = 2'd0; cnt_wr = 1; cnt_wdata = 16'd20; run(1); cnt_wr = 0;
        mode_sel = 2'd1; period = 16'd5; n_wrap = 0;
        run(1);
        check("R4", "count returns to zero", int'(count), 0);
        check("R4", "no wrap", n_wrap, 0);

        // R6 up/down P=3
        cur_req = "R6";
        mode_sel = 2'd0; do_clear();
        mode_sel = 2'd3; period = 16'd3; n_wrap = 0; n_eq = 0;
        run(4);
        check("R6", "count falling", int'(count), 2);
        check("R6", "dir_down", int'(dir_down), 1);
        run(8);
        check("R6", "wraps in 12 ticks", n_wrap, 2);
        check("R6", "eq0 in 12 ticks", n_eq, 2);
        check("R6", "count at end", int'(count), 0);

        // R7 direction kept across hold
        cur_req = "R7";
        do_clear(); period = 16'd5;
        run(7);
        mode_sel = 2'd0;
        run(4);
        check("R7", "held count", int'(count), 3);
        check("R7", "held dir", int'(dir_down), 1);
        mode_sel = 2'd3;
        run(1);
        check("R7", "resumed downward", int'(count), 2);

        // R13 period lowered while rising
        cur_req = "R13";
        do_clear(); period = 16'd10;
        run(6);
        period = 16'd3;
        run(1);
        check("R13", "turned around", int'(count), 5);
        check("R13", "dir after turn", int'(dir_down), 1);
        period = 16'd8;
        run(1);
        check("R13", "still falling", int'(count), 4);
        run(4);
        check("R13", "reached zero", int'(count), 0);

        // R11 zero period
        cur_req = "R11";
        mode_sel = 2'd1; period = 16'd10;
        run(4);
        period = 16'd0; n_wrap = 0; n_eq = 0;
        run(3);
        check("R11", "held at zero", int'(count), 0);
        check("R11", "no events", n_wrap + n_eq, 0);
        period = 16'd4;
        run(2);
        check("R11", "restart upward", int'(count), 2);

        // R9 divider, R8 prescaler clear
        cur_req = "R9";
        period = 16'd100; div_sel = 2'd3; do_clear();
        run(24);
        check("R9", "div8 after 24 ticks", int'(count), 3);
        div_sel = 2'd1; do_clear();
        run(6);
        check("R9", "div2 after 6 ticks", int'(count), 3);
        div_sel = 2'd0;

        // R10 sources
        cur_req = "R10";
        mode_sel = 2'd2; period = 16'hFFFF; aux_tick = 0; src_sel = 2'd0;
        do_clear();
        for (int k = 0; k < 3; k++) begin
            ext_lvl = 1; run(2); ext_lvl = 0; run(2);
        end
        check("R10", "rising edges", int'(count), 3);
        src_sel = 2'd3; do_clear();
        for (int k = 0; k < 3; k++) begin
            ext_lvl = 1; run(2); ext_lvl = 0; run(2);
        end
        check("R10", "falling edges", int'(count), 3);
        src_sel = 2'd2; aux_tick = 1; do_clear();
        for (int k = 0; k < 4; k++) begin
            sub_tick = 1; run(1); sub_tick = 0; run(1);
        end
        check("R10", "sub ticks only", int'(count), 4);

        // R8 / R12 priority
        cur_req = "R8";
        src_sel = 2'd1;
        run(5);
        clr = 1; cnt_wr = 1; cnt_wdata = 16'd77; run(1); clr = 0;
        check("R8", "clear beats write", int'(count), 0);
        cur_req = "R12";
        run(1); cnt_wr = 0;
        check("R12", "write beats tick", int'(count), 77);
        run(1);
        check("R12", "counts after write", int'(count), 78);

        summary();
        $finish;
    end

endmodule